// File: doc/BRIEF.md
# Bootstrap Program-Load Controller

This block puts the processor into a bootstrap state after the operator lowers one of three load-source switches (paper tape, punched card or bulk memory) and presses the ON button. It clears the B, P and I registers, holds P at zero, and masks every interrupt response address from 203 octal upward. It then writes a short fixed set of words into core memory and preloads the A and B registers with a canned reader-start code and an I/O command. When the machine is later switched to automatic mode, the CPU itself runs that command and the external device moves the loader into memory.

For reader sources, the block zeroes location 0 and writes a transfer control word into interrupt response locations 201 and 202 octal. The control word asks for 63 words of 4 characters each, stored from location 1 upward. For the bulk source, only location 0 is zeroed. Location 0 is the pointer word, so the bulk device copies 100 octal words from its address 0 into core address 0. The block stays in the hold state until the operator raises the switch that started the load.

Top module: `boot_loader_ctl`

## Requirements
- R1: After reset, every strobe, request and data output is zero, `load_active` is low and `src_sel` is 0.
- R2: When ON is sampled high while at least one source switch is lowered and the block is idle, `clr_bpi` goes high for exactly one cycle in the next cycle. When ON is pressed with no switch lowered, nothing happens.
- R3: Only one source is taken, with priority bulk, then tape, then card. `src_sel` holds the taken source for the whole load, encoded as 1 = tape, 2 = card, 3 = bulk.
- R4: From the clear cycle until the load ends, `p_hold` and `irq_mask_hi` stay high. `irq_force_lo`, which enables responses 201 and 202 octal regardless of the normal enable switch, is high over the same span for tape and card loads only.
- R5: A reader load issues three store requests in this order: address 0 with data 0, then address 201 octal, then address 202 octal. Both of the later two stores carry the control word. `mem_store` is high with every request.
- R6: The control word holds the start address in bits [11:0], characters per word in bits [14:12] and the word count in bits [20:15]. All other bits are zero. The start address is 1 and the word count is 63. The characters field holds the per-word character count, or that count minus one when `CPW_MINUS1` is set. Tape uses `TAPE_CPW` characters per word and card uses `CARD_CPW`.
- R7: Each request holds its address and data until `mem_rel` is sampled high. The next request, or the preload cycle, follows in the cycle after that.
- R8: A bulk load issues one store (address 0, data 0) and then goes straight to the preload.
- R9: Preload is a single cycle after the last release. `b_load` carries 25027000 octal for tape, 25527000 octal for card and 25041000 octal for bulk. `a_load` with 21 octal happens only for tape and card.
- R10: In the hold state after the preload, raising the taken source's switch returns the block to idle in the next cycle. Other switches and further ON presses have no effect while a load is active, and a switch raised before the preload takes effect only once the hold state is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_tape | input | 1 | Tape load switch lowered |
| sw_card | input | 1 | Card load switch lowered |
| sw_bulk | input | 1 | Bulk load switch lowered |
| on_btn | input | 1 | ON (initialize) button |
| mem_rel | input | 1 | Memory release acknowledge for the current request |
| clr_bpi | output | 1 | One-cycle clear of B, P and I |
| p_hold | output | 1 | Hold P at zero |
| irq_mask_hi | output | 1 | Inhibit interrupt responses 203 octal and above |
| irq_force_lo | output | 1 | Force-enable interrupt responses 201 and 202 octal |
| load_active | output | 1 | A load is in progress or being held |
| src_sel | output | 2 | Taken source: 0 none, 1 tape, 2 card, 3 bulk |
| mem_req | output | 1 | Memory request |
| mem_store | output | 1 | Request is a store |
| mem_addr | output | ADDR_W | Store address |
| mem_wdata | output | WORD_W | Store data |
| a_load | output | 1 | Load strobe for register A |
| a_data | output | WORD_W | Value for register A |
| b_load | output | 1 | Load strobe for register B |
| b_data | output | WORD_W | Value for register B |

## Verification
The bench builds the block with `CPW_MINUS1` set and `CARD_CPW` = 2. This reaches the minus-one encoding branch of the control-word generator and gives tape and card different control words, so a mix-up between the two reader words shows up in the store data. Memory release latencies of 0 to 3 cycles exercise the request hold. Lowering all three switches at once exercises the priority order. An early switch release during the store phase tests that release takes effect only from the hold state.

// File: rtl/boot_pkg.sv
package boot_pkg;
   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_CLR  = 3'd1,
      S_ST0  = 3'd2,
      S_ST1  = 3'd3,
      S_ST2  = 3'd4,
      S_PRE  = 3'd5,
      S_HOLD = 3'd6
   } seq_t;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_TAPE = 2'd1,
      SRC_CARD = 2'd2,
      SRC_BULK = 2'd3
   } src_t;
endpackage

// File: rtl/boot_src_pick.sv
module boot_src_pick
   import boot_pkg::*;
(
   input  logic sw_tape,
   input  logic sw_card,
   input  logic sw_bulk,
   output src_t pick
);
   // fixed priority: bulk over tape over card
   always_comb begin
      if (sw_bulk)      pick = SRC_BULK;
      else if (sw_tape) pick = SRC_TAPE;
      else if (sw_card) pick = SRC_CARD;
      else              pick = SRC_NONE;
   end
endmodule

// File: rtl/boot_ctlword.sv
module boot_ctlword #(
   parameter int WORD_W     = 24,
   parameter int CNT_LSB    = 15,
   parameter int CNT_W      = 6,
   parameter int CPW_LSB    = 12,
   parameter int CPW_W      = 3,
   parameter int ADR_LSB    = 0,
   parameter int ADR_W      = 12,
   parameter bit CPW_MINUS1 = 1'b0,
   parameter int WORDS      = 63,
   parameter int CPW        = 4,
   parameter int START      = 1
) (
   output logic [WORD_W-1:0] word
);
   localparam int CPW_CODE = CPW_MINUS1 ? CPW - 1 : CPW;

   // elaboration-time parameter checks
   if (CNT_LSB + CNT_W > WORD_W)  begin : g_bad_cnt $error("count field exceeds word"); end
   if (CPW_LSB + CPW_W > WORD_W)  begin : g_bad_cpw $error("chars field exceeds word"); end
   if (ADR_LSB + ADR_W > WORD_W)  begin : g_bad_adr $error("address field exceeds word"); end
   if (WORDS >= (1 << CNT_W))     begin : g_bad_wds $error("word count does not fit"); end
   if (CPW_CODE >= (1 << CPW_W) || CPW_CODE < 0) begin : g_bad_cc $error("chars code does not fit"); end
   if (START >= (1 << ADR_W))     begin : g_bad_st  $error("start address does not fit"); end
   if ((ADR_LSB + ADR_W > CPW_LSB && CPW_LSB + CPW_W > ADR_LSB) ||
       (CPW_LSB + CPW_W > CNT_LSB && CNT_LSB + CNT_W > CPW_LSB) ||
       (ADR_LSB + ADR_W > CNT_LSB && CNT_LSB + CNT_W > ADR_LSB))
   begin : g_overlap $error("control word fields overlap"); end

   logic [CPW_W-1:0] cpw_f;

   // encoding variant of the characters-per-word field
   if (CPW_MINUS1) begin : g_cpw_m1
      assign cpw_f = CPW_W'(CPW - 1);
   end else begin : g_cpw_raw
      assign cpw_f = CPW_W'(CPW);
   end

   always_comb begin
      word = '0;
      word[CNT_LSB +: CNT_W] = CNT_W'(WORDS);
      word[CPW_LSB +: CPW_W] = cpw_f;
      word[ADR_LSB +: ADR_W] = ADR_W'(START);
   end
endmodule

// File: rtl/boot_seq.sv
module boot_seq
   import boot_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic on_btn,
   input  logic mem_rel,
   input  src_t pick,
   input  logic sw_tape,
   input  logic sw_card,
   input  logic sw_bulk,
   output seq_t state,
   output src_t src
);
   seq_t state_nx;
   src_t src_nx;
   logic still_down;

   always_comb begin
      unique case (src)
         SRC_TAPE: still_down = sw_tape;
         SRC_CARD: still_down = sw_card;
         SRC_BULK: still_down = sw_bulk;
         default:  still_down = 1'b0;
      endcase
   end

   always_comb begin
      state_nx = state;
      src_nx   = src;
      unique case (state)
         S_IDLE: if (on_btn && pick != SRC_NONE) begin
            state_nx = S_CLR;
            src_nx   = pick;
         end
         S_CLR:  state_nx = S_ST0;
         S_ST0:  if (mem_rel) state_nx = (src == SRC_BULK) ? S_PRE : S_ST1;
         S_ST1:  if (mem_rel) state_nx = S_ST2;
         S_ST2:  if (mem_rel) state_nx = S_PRE;
         S_PRE:  state_nx = S_HOLD;
         S_HOLD: if (!still_down) begin
            state_nx = S_IDLE;
            src_nx   = SRC_NONE;
         end
         default: begin
            state_nx = S_IDLE;
            src_nx   = SRC_NONE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         src   <= SRC_NONE;
      end else begin
         state <= state_nx;
         src   <= src_nx;
      end
   end
endmodule

// File: rtl/boot_loader_ctl.sv
module boot_loader_ctl
   import boot_pkg::*;
#(
   parameter int          WORD_W     = 24,
   parameter int          ADDR_W     = 15,
   parameter int          CW_CNT_LSB = 15,
   parameter int          CW_CNT_W   = 6,
   parameter int          CW_CPW_LSB = 12,
   parameter int          CW_CPW_W   = 3,
   parameter int          CW_ADR_LSB = 0,
   parameter int          CW_ADR_W   = 12,
   parameter bit          CPW_MINUS1 = 1'b0,
   parameter int          LOAD_WORDS = 63,
   parameter int          LOAD_START = 1,
   parameter int          TAPE_CPW   = 4,
   parameter int          CARD_CPW   = 4,
   parameter int unsigned VEC_LO     = 'o201,
   parameter int unsigned VEC_HI     = 'o202,
   parameter int unsigned A_START    = 'o21,
   parameter int unsigned B_TAPE     = 'o25027000,
   parameter int unsigned B_CARD     = 'o25527000,
   parameter int unsigned B_BULK     = 'o25041000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_tape,
   input  logic              sw_card,
   input  logic              sw_bulk,
   input  logic              on_btn,
   input  logic              mem_rel,
   output logic              clr_bpi,
   output logic              p_hold,
   output logic              irq_mask_hi,
   output logic              irq_force_lo,
   output logic              load_active,
   output logic [1:0]        src_sel,
   output logic              mem_req,
   output logic              mem_store,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              a_load,
   output logic [WORD_W-1:0] a_data,
   output logic              b_load,
   output logic [WORD_W-1:0] b_data
);
   localparam int VEC_BITS = $clog2(VEC_HI + 1);

   if (ADDR_W < VEC_BITS) begin : g_bad_addr $error("address too narrow for vectors"); end
   if (WORD_W < 24)       begin : g_bad_word $error("word too narrow for commands"); end

   src_t pick, src;
   seq_t state;
   logic [WORD_W-1:0] tape_cw, card_cw, rd_cw, boot_b;

   boot_src_pick u_pick (
      .sw_tape (sw_tape),
      .sw_card (sw_card),
      .sw_bulk (sw_bulk),
      .pick    (pick)
   );

   boot_ctlword #(
      .WORD_W(WORD_W), .CNT_LSB(CW_CNT_LSB), .CNT_W(CW_CNT_W),
      .CPW_LSB(CW_CPW_LSB), .CPW_W(CW_CPW_W), .ADR_LSB(CW_ADR_LSB),
      .ADR_W(CW_ADR_W), .CPW_MINUS1(CPW_MINUS1), .WORDS(LOAD_WORDS),
      .CPW(TAPE_CPW), .START(LOAD_START)
   ) u_cw_tape (
      .word (tape_cw)
   );

   boot_ctlword #(
      .WORD_W(WORD_W), .CNT_LSB(CW_CNT_LSB), .CNT_W(CW_CNT_W),
      .CPW_LSB(CW_CPW_LSB), .CPW_W(CW_CPW_W), .ADR_LSB(CW_ADR_LSB),
      .ADR_W(CW_ADR_W), .CPW_MINUS1(CPW_MINUS1), .WORDS(LOAD_WORDS),
      .CPW(CARD_CPW), .START(LOAD_START)
   ) u_cw_card (
      .word (card_cw)
   );

   boot_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .on_btn  (on_btn),
      .mem_rel (mem_rel),
      .pick    (pick),
      .sw_tape (sw_tape),
      .sw_card (sw_card),
      .sw_bulk (sw_bulk),
      .state   (state),
      .src     (src)
   );

   assign rd_cw = (src == SRC_CARD) ? card_cw : tape_cw;

   always_comb begin
      unique case (src)
         SRC_TAPE: boot_b = WORD_W'(B_TAPE);
         SRC_CARD: boot_b = WORD_W'(B_CARD);
         SRC_BULK: boot_b = WORD_W'(B_BULK);
         default:  boot_b = '0;
      endcase
   end

   always_comb begin
      clr_bpi   = 1'b0;
      mem_req   = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      a_load    = 1'b0;
      a_data    = '0;
      b_load    = 1'b0;
      b_data    = '0;
      unique case (state)
         S_CLR: clr_bpi = 1'b1;
         S_ST0: mem_req = 1'b1;
         S_ST1: begin
            mem_req   = 1'b1;
            mem_addr  = ADDR_W'(VEC_LO);
            mem_wdata = rd_cw;
         end
         S_ST2: begin
            mem_req   = 1'b1;
            mem_addr  = ADDR_W'(VEC_HI);
            mem_wdata = rd_cw;
         end
         S_PRE: begin
            b_load = 1'b1;
            b_data = boot_b;
            if (src != SRC_BULK) begin
               a_load = 1'b1;
               a_data = WORD_W'(A_START);
            end
         end
         default: ;
      endcase
   end

   assign mem_store    = mem_req;
   assign load_active  = (state != S_IDLE);
   assign p_hold       = load_active;
   assign irq_mask_hi  = load_active;
   assign irq_force_lo = load_active && (src != SRC_BULK);
   assign src_sel      = src;
endmodule

// File: rtl/boot_loader_ctl_chk.sv
module boot_loader_ctl_chk #(
   parameter int ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rel,
   input logic              clr_bpi,
   input logic              p_hold,
   input logic              irq_mask_hi,
   input logic              irq_force_lo,
   input logic              load_active,
   input logic [1:0]        src_sel,
   input logic              mem_req,
   input logic              mem_store,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              a_load,
   input logic              b_load
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !load_active |-> !mem_req && !a_load && !b_load && !clr_bpi);

   p_clr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_bpi |=> !clr_bpi);

   p_clr_then_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_bpi |=> mem_req && mem_addr == '0);

   p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_active |-> p_hold && irq_mask_hi);

   p_force_reader_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_force_lo |-> load_active && src_sel != 2'd3);

   p_store_with_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_store);

   p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rel |=> mem_req && $stable(mem_addr));

   p_bulk_ptr_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && src_sel == 2'd3 |-> mem_addr == '0);

   p_a_reader_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      a_load |-> b_load && src_sel != 2'd3);
endmodule

bind boot_loader_ctl boot_loader_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/boot_loader_ctl_bench.sv
module boot_loader_ctl_bench;
   localparam int WORD_W = 24;
   localparam int ADDR_W = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_tape = 0, sw_card = 0, sw_bulk = 0, on_btn = 0, mem_rel = 0;
   logic clr_bpi, p_hold, irq_mask_hi, irq_force_lo, load_active;
   logic [1:0] src_sel;
   logic mem_req, mem_store, a_load, b_load;
   logic [ADDR_W-1:0] mem_addr;
   logic [WORD_W-1:0] mem_wdata, a_data, b_data;

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int wcnt = 0;
   int ph = 0;
   int src = 0;
   bit done = 0;

   always #10 clk = ~clk;

   boot_loader_ctl #(.CPW_MINUS1(1'b1), .CARD_CPW(2)) u_boot_loader_ctl (.*);

   // R6 layout: address [11:0]=1, chars [14:12] (count-1 here), words [20:15]=63
   localparam logic [23:0] CW_TAPE = (24'd63 << 15) | (24'd3 << 12) | 24'd1;
   localparam logic [23:0] CW_CARD = (24'd63 << 15) | (24'd1 << 12) | 24'd1;

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model: phase 0 idle, 1 clear, 2..4 stores, 5 preload, 6 hold
   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; src = 0;
      end else begin
         case (ph)
            0: if (on_btn && (sw_bulk || sw_tape || sw_card)) begin
                  ph = 1;
                  src = sw_bulk ? 3 : (sw_tape ? 1 : 2);
               end
            1: ph = 2;
            2: if (mem_rel) ph = (src == 3) ? 5 : 3;
            3: if (mem_rel) ph = 4;
            4: if (mem_rel) ph = 5;
            5: ph = 6;
            6: if (!(src == 1 ? sw_tape : (src == 2 ? sw_card : sw_bulk))) begin
                  ph = 0; src = 0;
               end
            default: ph = 0;
         endcase
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         automatic bit act  = (ph != 0);
         automatic bit req  = (ph >= 2 && ph <= 4);
         automatic longint ea = (ph == 3) ? 'o201 : (ph == 4) ? 'o202 : 0;
         automatic longint cw = (src == 2) ? CW_CARD : CW_TAPE;
         automatic longint ed = (ph == 3 || ph == 4) ? cw : 0;
         automatic longint eb = (ph != 5) ? 0 :
                                (src == 1) ? 'o25027000 : (src == 2) ? 'o25527000 : 'o25041000;
         chk("R2 clr_bpi", clr_bpi, ph == 1);
         chk("R3 src_sel", src_sel, src);
         chk("R4 p_hold/irq_mask_hi", {p_hold, irq_mask_hi}, {act, act});
         chk("R4 irq_force_lo", irq_force_lo, act && src != 3);
         chk("R7 mem_req/mem_store", {mem_req, mem_store}, {req, req});
         chk("R5 mem_addr", mem_addr, ea);
         chk("R6 mem_wdata", mem_wdata, ed);
         chk("R8 R9 b_load/b_data", {b_load, b_data}, {ph == 5, eb[23:0]});
         chk("R9 a_load/a_data", {a_load, a_data},
             {ph == 5 && src != 3, (ph == 5 && src != 3) ? 24'o21 : 24'd0});
         chk("R10 load_active", load_active, act);
      end
   end

   // memory responder: release after lat waiting cycles
   always @(negedge clk) begin
      #2;
      if (mem_rel) begin
         mem_rel = 0; wcnt = 0;
      end else if (mem_req) begin
         if (wcnt >= lat) mem_rel = 1;
         else wcnt++;
      end else wcnt = 0;
   end

   task automatic tick(input int n);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic press_on();
      on_btn = 1; tick(1); on_btn = 0;
   endtask

   initial begin
      tick(3);
      // R1 reset state
      chk("R1 reset outputs", {clr_bpi, p_hold, irq_mask_hi, irq_force_lo, load_active,
          src_sel, mem_req, mem_store, a_load, b_load}, 0);
      chk("R1 reset data", {mem_addr, mem_wdata, a_data, b_data}, 0);
      rst_n = 1; tick(2);
      // R2 ON with no switch lowered: stays idle
      press_on(); tick(3);
      chk("R2 ignored ON", load_active, 0);
      // tape load, zero latency; R10 other switch and ON ignored in hold
      lat = 0; sw_tape = 1; press_on(); tick(12);
      sw_card = 1; tick(2); press_on(); sw_card = 0; tick(2);
      chk("R10 still active", load_active, 1);
      sw_tape = 0; tick(3);
      chk("R10 released", load_active, 0);
      // card load, long latency
      lat = 3; sw_card = 1; press_on(); tick(25); sw_card = 0; tick(3);
      // all lowered: bulk wins (R3), single store (R8)
      lat = 1; sw_bulk = 1; sw_tape = 1; sw_card = 1; press_on(); tick(12);
      sw_tape = 0; tick(2); sw_card = 0; tick(2);
      chk("R10 bulk held", load_active, 1);
      sw_bulk = 0; tick(3);
      // early release during stores (R10): finishes then returns idle
      lat = 2; sw_tape = 1; press_on(); tick(3); sw_tape = 0; tick(15);
      chk("R10 early release idle", load_active, 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule